// File: doc/BRIEF.md
# MII Receive Frame Checker

This block sits on the receive side of a 10/100 media-independent interface. It follows the nibble stream from the PHY (data, data-valid and error lines) one nibble per clock. It strips and checks the preamble, packs the rest into bytes and picks the header fields out of those bytes. When data-valid drops, it issues one 16-bit status word that classifies the frame, along with an accept or reject decision from a destination address filter.

The status word reports these conditions:

- overrun from the downstream buffer
- frame too short
- carrier event in the gap before the frame
- code violation
- length mismatch and length out of range
- VLAN tag, broadcast and multicast destinations
- dropped or over-long reception
- CRC failure, with the CRC result supplied by an external checker
- odd nibble count

The "received intact" bit summarises the error bits. Static configuration inputs set the preamble purity check, the long-preamble rejection and the filter modes.

Top module: `mii_rx_frame_checker`

## Requirements
- R1: After reset `stat_vld`, `stat_word` and `stat_accept` are 0. `stat_vld` is a one-cycle pulse in the cycle after the first clock with `mii_rxdv` low that follows a clock with `mii_rxdv` high. `stat_accept` is only ever high together with `stat_vld`.
- R2: The preamble is the nibbles received before the first 0xD nibble. It is pure when all of those nibbles are 0x5 and a 0xD nibble arrives. With `cfg_pure_chk` set, an impure preamble sets bit 12 and the frame is rejected.
- R3: With `cfg_long_pre_rej` set, more than PRE_LIMIT_NIBS (22) nibbles before the 0xD nibble sets bit 12 and rejects the frame. Exactly 22 nibbles does not.
- R4: A reception with more than LONG_NIBBLES data-valid clocks (12,500 clocks, which is 50,000 bit times) sets bit 12 and rejects the frame.
- R5: Data nibbles after the 0xD nibble are packed low nibble first. An odd count of data nibbles sets bit 14.
- R6: A clock with `mii_rxer`=1, `mii_rxdv`=0 and `mii_rxd`=0xE sets bit 2 in the next status word. Any other pattern with data-valid low does not.
- R7: `mii_rxer` high on any data-valid clock sets bit 3. `buf_overrun` high on any data-valid clock sets bit 0.
- R8: The length/type field is taken big-endian from bytes 12 and 13, with byte 0 being the first destination byte. With at least 14 bytes received:
  - A value from 1519 to 1535 sets bit 5.
  - A value of 0x8100 sets bit 7.
  - With at least 18 bytes, a value of 1518 or less that differs from the byte count minus 18 sets bit 4.
- R9: Fewer than MIN_FRAME_BYTES (64) whole bytes sets bit 1. Exactly 64 does not.
- R10: With at least 6 bytes received, a destination of all 0xFF sets bit 8. A destination whose first byte has bit 0 set, and which is not broadcast, sets bit 9.
- R11: `crc_match` low in the cycle data-valid falls sets bit 13. Bit 15 is set exactly when bits 0, 1, 3, 4, 5, 12, 13 and 14 are all clear. Bits 2, 7, 8 and 9 do not affect it.
- R12: `stat_accept` requires all of the following:
  - bit 12 is clear
  - a 0xD nibble was seen
  - at least 6 bytes were received
  - one of these filter conditions holds:
    - `cfg_promisc` is set
    - a broadcast with `cfg_bcast_en` set
    - a multicast with `cfg_mcast_en` set
    - a unicast destination equal to `station_mac`, where bits 47:40 are byte 0

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one nibble per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mii_rxd | input | 4 | Receive nibble from the PHY |
| mii_rxdv | input | 1 | Receive data valid |
| mii_rxer | input | 1 | Receive error from the PHY |
| crc_match | input | 1 | External CRC result, sampled in the cycle data-valid falls |
| buf_overrun | input | 1 | Downstream buffer overrun indication |
| cfg_pure_chk | input | 1 | Enable preamble purity check |
| cfg_long_pre_rej | input | 1 | Enable long-preamble rejection |
| cfg_bcast_en | input | 1 | Accept broadcast frames |
| cfg_mcast_en | input | 1 | Accept any multicast frame |
| cfg_promisc | input | 1 | Accept all frames that were not dropped |
| station_mac | input | 48 | Own unicast address, byte 0 in bits 47:40 |
| stat_vld | output | 1 | Status word valid pulse |
| stat_word | output | 16 | Frame status word |
| stat_accept | output | 1 | Address filter decision, valid with `stat_vld` |

## Verification
The bench builds the block with LONG_NIBBLES lowered to 300 and keeps MIN_FRAME_BYTES at 64, PRE_LIMIT_NIBS at 22 and CNT_W at 16. With the lower limit, frames of about 142 bytes land on either side of the long-event threshold. The same frame sizes still cover the 63/64-byte short boundary and the 22/23-nibble preamble boundary. A behavioural model predicts the data-valid-fall pulse on every clock and a status word and accept flag for every frame. Frames vary the destination kind, the length/type value, the preamble shape, odd nibbles, injected errors and the filter settings.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_DATA = 2'd2
  } rx_phase_t;

  localparam logic [3:0] NIB_PRE     = 4'h5;
  localparam logic [3:0] NIB_SFD     = 4'hD;
  localparam logic [3:0] NIB_CARRIER = 4'hE;

  localparam int ST_OVR    = 0;
  localparam int ST_SHORT  = 1;
  localparam int ST_CARR   = 2;
  localparam int ST_CODEV  = 3;
  localparam int ST_LENMIS = 4;
  localparam int ST_LOOR   = 5;
  localparam int ST_VLAN   = 7;
  localparam int ST_BCAST  = 8;
  localparam int ST_MCAST  = 9;
  localparam int ST_DROP   = 12;
  localparam int ST_CRC    = 13;
  localparam int ST_ALIGN  = 14;
  localparam int ST_INTACT = 15;

  localparam logic [15:0] ERR_MASK = 16'h703B;

  localparam int HDR_BYTES    = 14;
  localparam int MIN_LEN_BYTES = 18;
  localparam int MAX_LEN_FIELD = 1518;
  localparam int MIN_TYPE_FIELD = 1536;
  localparam logic [15:0] VLAN_TPID = 16'h8100;

endpackage

// File: rtl/rxfc_preamble.sv
module rxfc_preamble
  import rxfc_pkg::*;
#(
  parameter int PRE_LIMIT = 22
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rxd,
  input  logic       rxdv,
  output rx_phase_t  phase_o,
  output logic       start_o,
  output logic       end_o,
  output logic       data_nib_o,
  output logic       impure_o,
  output logic       long_o
);

  localparam int CW = $clog2(PRE_LIMIT + 2);
  localparam logic [CW-1:0] CSAT = CW'(PRE_LIMIT + 1);
  localparam logic [CW-1:0] CLIM = CW'(PRE_LIMIT);

  rx_phase_t     phase;
  logic [CW-1:0] pre_cnt;
  logic          pre_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      pre_cnt <= '0;
      pre_bad <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (rxdv) begin
            if (rxd == NIB_SFD) begin
              phase   <= PH_DATA;
              pre_cnt <= '0;
              pre_bad <= 1'b0;
            end else begin
              phase   <= PH_PRE;
              pre_cnt <= CW'(1);
              pre_bad <= (rxd != NIB_PRE);
            end
          end
        end
        PH_PRE: begin
          if (!rxdv) begin
            phase <= PH_IDLE;
          end else if (rxd == NIB_SFD) begin
            phase <= PH_DATA;
          end else begin
            if (pre_cnt != CSAT) pre_cnt <= pre_cnt + CW'(1);
            if (rxd != NIB_PRE) pre_bad <= 1'b1;
          end
        end
        PH_DATA: begin
          if (!rxdv) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    phase_o    = phase;
    start_o    = rxdv && (phase == PH_IDLE);
    end_o      = !rxdv && (phase != PH_IDLE);
    data_nib_o = rxdv && (phase == PH_DATA);
    impure_o   = pre_bad || (phase != PH_DATA);
    long_o     = pre_cnt > CLIM;
  end

endmodule

// File: rtl/rxfc_nibble_pack.sv
module rxfc_nibble_pack #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             nib_vld,
  input  logic [3:0]       nib,
  output logic [CNT_W-1:0] nib_cnt_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-2:0] byte_idx_o
);

  logic [CNT_W-1:0] nib_cnt;
  logic [3:0]       lo_nib;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      nib_cnt <= '0;
      lo_nib  <= '0;
    end else if (nib_vld) begin
      if (nib_cnt != '1) nib_cnt <= nib_cnt + CNT_W'(1);
      if (!nib_cnt[0]) lo_nib <= nib;
    end
  end

  always_comb begin
    nib_cnt_o  = nib_cnt;
    byte_vld_o = nib_vld && nib_cnt[0];
    byte_o     = {nib, lo_nib};
    byte_idx_o = nib_cnt[CNT_W-1:1];
  end

endmodule

// File: rtl/rxfc_hdr_capture.sv
module rxfc_hdr_capture #(
  parameter int IDX_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             byte_vld,
  input  logic [7:0]       byte_i,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [47:0]      station_mac,
  output logic             all_ones_o,
  output logic             group_o,
  output logic             uc_hit_o,
  output logic [15:0]      len_type_o
);

  localparam int ADDR_BYTES = 6;
  localparam int LT_HI_IDX  = 12;
  localparam int LT_LO_IDX  = 13;

  logic        all_ones;
  logic        group;
  logic        uc_hit;
  logic [15:0] len_type;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      all_ones <= 1'b1;
      group    <= 1'b0;
      uc_hit   <= 1'b1;
      len_type <= '0;
    end else if (byte_vld) begin
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (byte_idx == IDX_W'(i)) begin
          all_ones <= all_ones && (byte_i == 8'hFF);
          uc_hit   <= uc_hit && (byte_i == station_mac[8*(ADDR_BYTES-1-i) +: 8]);
        end
      end
      if (byte_idx == IDX_W'(0))         group <= byte_i[0];
      if (byte_idx == IDX_W'(LT_HI_IDX)) len_type[15:8] <= byte_i;
      if (byte_idx == IDX_W'(LT_LO_IDX)) len_type[7:0]  <= byte_i;
    end
  end

  assign all_ones_o = all_ones;
  assign group_o    = group;
  assign uc_hit_o   = uc_hit;
  assign len_type_o = len_type;

endmodule

// File: rtl/mii_rx_frame_checker.sv
module mii_rx_frame_checker
  import rxfc_pkg::*;
#(
  parameter int LONG_NIBBLES    = 12500,
  parameter int MIN_FRAME_BYTES = 64,
  parameter int PRE_LIMIT_NIBS  = 22,
  parameter int CNT_W           = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  mii_rxd,
  input  logic        mii_rxdv,
  input  logic        mii_rxer,
  input  logic        crc_match,
  input  logic        buf_overrun,
  input  logic        cfg_pure_chk,
  input  logic        cfg_long_pre_rej,
  input  logic        cfg_bcast_en,
  input  logic        cfg_mcast_en,
  input  logic        cfg_promisc,
  input  logic [47:0] station_mac,
  output logic        stat_vld,
  output logic [15:0] stat_word,
  output logic        stat_accept
);

  localparam int IDX_W = CNT_W - 1;
  localparam int DUR_W = $clog2(LONG_NIBBLES + 2);
  localparam logic [DUR_W-1:0] DUR_SAT = DUR_W'(LONG_NIBBLES + 1);
  localparam logic [DUR_W-1:0] DUR_LIM = DUR_W'(LONG_NIBBLES);

  rx_phase_t        phase;
  logic             frm_start, frm_end, dnib_vld, pre_impure, pre_long;
  logic [CNT_W-1:0] nib_cnt;
  logic             byte_vld;
  logic [7:0]       byte_val;
  logic [IDX_W-1:0] byte_idx;
  logic             da_all_ones, da_group, da_uc_hit;
  logic [15:0]      len_type;

  rxfc_preamble #(.PRE_LIMIT(PRE_LIMIT_NIBS)) u_pre (
    .clk(clk), .rst(rst), .rxd(mii_rxd), .rxdv(mii_rxdv),
    .phase_o(phase), .start_o(frm_start), .end_o(frm_end),
    .data_nib_o(dnib_vld), .impure_o(pre_impure), .long_o(pre_long)
  );

  rxfc_nibble_pack #(.CNT_W(CNT_W)) u_pack (
    .clk(clk), .rst(rst), .clr(frm_start), .nib_vld(dnib_vld), .nib(mii_rxd),
    .nib_cnt_o(nib_cnt), .byte_vld_o(byte_vld), .byte_o(byte_val),
    .byte_idx_o(byte_idx)
  );

  rxfc_hdr_capture #(.IDX_W(IDX_W)) u_hdr (
    .clk(clk), .rst(rst), .clr(frm_start), .byte_vld(byte_vld),
    .byte_i(byte_val), .byte_idx(byte_idx), .station_mac(station_mac),
    .all_ones_o(da_all_ones), .group_o(da_group), .uc_hit_o(da_uc_hit),
    .len_type_o(len_type)
  );

  // Per-frame event accumulators
  logic [DUR_W-1:0] dur_cnt;
  logic             cv_seen, ovr_seen, carrier_seen;
  logic             in_frame, carrier_now;

  assign in_frame    = (phase != PH_IDLE);
  assign carrier_now = mii_rxer && !mii_rxdv && (mii_rxd == NIB_CARRIER);

  always_ff @(posedge clk) begin
    if (rst) begin
      dur_cnt  <= '0;
      cv_seen  <= 1'b0;
      ovr_seen <= 1'b0;
    end else if (frm_start) begin
      dur_cnt  <= DUR_W'(1);
      cv_seen  <= mii_rxer;
      ovr_seen <= buf_overrun;
    end else if (in_frame && mii_rxdv) begin
      if (dur_cnt != DUR_SAT) dur_cnt <= dur_cnt + DUR_W'(1);
      if (mii_rxer)    cv_seen  <= 1'b1;
      if (buf_overrun) ovr_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              carrier_seen <= 1'b0;
    else if (frm_end)     carrier_seen <= carrier_now;
    else if (carrier_now) carrier_seen <= 1'b1;
  end

  // Status classification at frame end
  logic [31:0] bc32, lt32;
  logic        sfd_seen, long_evt, drop, addr_ok, accept_d;
  logic [15:0] word_d;

  always_comb begin
    bc32     = 32'(nib_cnt[CNT_W-1:1]);
    lt32     = 32'(len_type);
    sfd_seen = (phase == PH_DATA);
    long_evt = dur_cnt > DUR_LIM;
    addr_ok  = bc32 >= 32'd6;
    drop     = (cfg_pure_chk && pre_impure) || (cfg_long_pre_rej && pre_long) || long_evt;

    word_d            = '0;
    word_d[ST_OVR]    = ovr_seen;
    word_d[ST_SHORT]  = bc32 < 32'(MIN_FRAME_BYTES);
    word_d[ST_CARR]   = carrier_seen;
    word_d[ST_CODEV]  = cv_seen;
    word_d[ST_LENMIS] = (bc32 >= 32'(MIN_LEN_BYTES)) && (lt32 <= 32'(MAX_LEN_FIELD)) &&
                        (lt32 != bc32 - 32'(MIN_LEN_BYTES));
    word_d[ST_LOOR]   = (bc32 >= 32'(HDR_BYTES)) && (lt32 > 32'(MAX_LEN_FIELD)) &&
                        (lt32 < 32'(MIN_TYPE_FIELD));
    word_d[ST_VLAN]   = (bc32 >= 32'(HDR_BYTES)) && (len_type == VLAN_TPID);
    word_d[ST_BCAST]  = addr_ok && da_all_ones;
    word_d[ST_MCAST]  = addr_ok && da_group && !da_all_ones;
    word_d[ST_DROP]   = drop;
    word_d[ST_CRC]    = !crc_match;
    word_d[ST_ALIGN]  = nib_cnt[0];
    word_d[ST_INTACT] = ((word_d & ERR_MASK) == 16'h0);

    accept_d = !drop && sfd_seen && addr_ok &&
               (cfg_promisc ||
                (word_d[ST_BCAST] && cfg_bcast_en) ||
                (word_d[ST_MCAST] && cfg_mcast_en) ||
                (!da_group && da_uc_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_vld    <= 1'b0;
      stat_word   <= '0;
      stat_accept <= 1'b0;
    end else begin
      stat_vld    <= frm_end;
      stat_accept <= frm_end && accept_d;
      if (frm_end) stat_word <= word_d;
    end
  end

endmodule

// File: rtl/rxfc_checker.sv
module rxfc_checker (
  input logic        clk,
  input logic        rst,
  input logic        mii_rxdv,
  input logic        mii_rxer,
  input logic        buf_overrun,
  input logic        stat_vld,
  input logic [15:0] stat_word,
  input logic        stat_accept
);

  logic cv_q, ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cv_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else if (stat_vld) begin
      cv_q  <= mii_rxdv && mii_rxer;
      ovr_q <= mii_rxdv && buf_overrun;
    end else begin
      if (mii_rxdv && mii_rxer)    cv_q  <= 1'b1;
      if (mii_rxdv && buf_overrun) ovr_q <= 1'b1;
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    stat_vld |=> !stat_vld);                                           // R1
  AST_VLD_AFTER_DV_FALL: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> (!$past(mii_rxdv) && $past(mii_rxdv, 2)));            // R1
  AST_ACCEPT_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
    stat_accept |-> stat_vld);                                         // R1
  AST_CODEV_TRACK: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> (stat_word[3] == cv_q));                              // R7
  AST_OVR_TRACK: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> (stat_word[0] == ovr_q));                             // R7
  AST_DROP_REJECT: assert property (@(posedge clk) disable iff (rst)
    (stat_vld && stat_word[12]) |-> !stat_accept);                     // R12

endmodule

bind mii_rx_frame_checker rxfc_checker u_rxfc_checker (
  .clk(clk), .rst(rst), .mii_rxdv(mii_rxdv), .mii_rxer(mii_rxer),
  .buf_overrun(buf_overrun), .stat_vld(stat_vld), .stat_word(stat_word),
  .stat_accept(stat_accept)
);

// File: tb/test_mii_rx_frame_checker.sv
`timescale 1ns/1ps
module test_mii_rx_frame_checker;

  localparam int LONG_NIB = 300;
  localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER = 48'h02_99_88_77_66_55;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;

  typedef bit [7:0] u8_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] mii_rxd = '0;
  logic mii_rxdv = 1'b0, mii_rxer = 1'b0, crc_match = 1'b1, buf_overrun = 1'b0;
  logic cfg_pure_chk = 1'b1, cfg_long_pre_rej = 1'b1, cfg_bcast_en = 1'b1;
  logic cfg_mcast_en = 1'b0, cfg_promisc = 1'b0;
  logic [47:0] station_mac = STA;
  logic stat_vld, stat_accept;
  logic [15:0] stat_word;

  always #2 clk = ~clk;

  mii_rx_frame_checker #(.LONG_NIBBLES(LONG_NIB)) i_mii_rx_frame_checker (
    .clk(clk), .rst(rst), .mii_rxd(mii_rxd), .mii_rxdv(mii_rxdv),
    .mii_rxer(mii_rxer), .crc_match(crc_match), .buf_overrun(buf_overrun),
    .cfg_pure_chk(cfg_pure_chk), .cfg_long_pre_rej(cfg_long_pre_rej),
    .cfg_bcast_en(cfg_bcast_en), .cfg_mcast_en(cfg_mcast_en),
    .cfg_promisc(cfg_promisc), .station_mac(station_mac),
    .stat_vld(stat_vld), .stat_word(stat_word), .stat_accept(stat_accept)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit [15:0] exp_word_q[$];
  bit        exp_acc_q[$];
  string     exp_tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Timing model of the status pulse (R1)
  bit m_prev_dv = 1'b0;
  bit m_vld = 1'b0;
  always @(posedge clk) begin
    m_prev_dv <= rst ? 1'b0 : mii_rxdv;
    m_vld     <= !rst && m_prev_dv && !mii_rxdv;
  end

  always @(negedge clk) begin
    if (mon_on) begin
      check("R1 stat_vld timing", 32'(stat_vld), 32'(m_vld));
      if (!stat_accept || stat_vld) n_cmp++;
      else begin n_cmp++; n_bad++; $display("FAIL R1 accept without valid actual=1 expected=0"); end
      if (stat_vld) begin
        if (exp_word_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R1 unexpected status actual=%h expected=none", stat_word);
        end else begin
          string t;
          bit [15:0] w;
          bit a;
          t = exp_tag_q.pop_front();
          w = exp_word_q.pop_front();
          a = exp_acc_q.pop_front();
          check({t, " word"}, 32'(stat_word), 32'(w));
          check({t, " accept"}, 32'(stat_accept), 32'(a));
        end
      end
    end
  end

  task automatic do_frame(string tag, int npre, int bad_at, bit sfd,
                          logic [47:0] da, logic [15:0] lt, int total, bit odd,
                          int cv_at, bit ovr, bit crc, int car);
    u8_t bytes[$];
    bit [3:0] nq[$];
    bit [15:0] w;
    bit drop, acc, impure, bc, mc, uc;
    int n, dur, ltv;
    // build byte list
    for (int i = 0; i < 6; i++) bytes.push_back(da[8*(5-i) +: 8]);
    for (int i = 0; i < 6; i++) bytes.push_back(u8_t'(8'h02 + i));
    bytes.push_back(lt[15:8]);
    bytes.push_back(lt[7:0]);
    while (bytes.size() < total) bytes.push_back(u8_t'(bytes.size() * 7));
    while (bytes.size() > total) void'(bytes.pop_back());
    // expected result
    n = sfd ? total : 0;
    impure = (bad_at >= 0 && bad_at < npre) || !sfd;
    dur = npre + (sfd ? 1 : 0) + (sfd ? 2 * total + (odd ? 1 : 0) : 0);
    drop = (cfg_pure_chk && impure) || (cfg_long_pre_rej && npre > 22) || (dur > LONG_NIB);
    ltv = (n >= 14) ? {bytes[12], bytes[13]} : 0;
    bc = (n >= 6) && (da == BCAST);
    mc = (n >= 6) && da[40] && !bc;
    uc = (n >= 6) && !da[40] && (da == station_mac);
    w = '0;
    w[0]  = ovr;
    w[1]  = n < 64;
    w[2]  = (car == 1);
    w[3]  = (cv_at >= 0);
    w[4]  = (n >= 18) && (ltv <= 1518) && (ltv != n - 18);
    w[5]  = (n >= 14) && (ltv >= 1519) && (ltv <= 1535);
    w[7]  = (n >= 14) && (ltv == 32'h8100);
    w[8]  = bc;
    w[9]  = mc;
    w[12] = drop;
    w[13] = !crc;
    w[14] = sfd && odd;
    w[15] = ((w & 16'h703B) == 0);
    acc = !drop && sfd && (n >= 6) &&
          (cfg_promisc || (bc && cfg_bcast_en) || (mc && cfg_mcast_en) || uc);
    exp_word_q.push_back(w);
    exp_acc_q.push_back(acc);
    exp_tag_q.push_back(tag);
    // nibble sequence
    for (int i = 0; i < npre; i++) nq.push_back((i == bad_at) ? 4'h7 : 4'h5);
    if (sfd) begin
      nq.push_back(4'hD);
      foreach (bytes[i]) begin
        nq.push_back(bytes[i][3:0]);
        nq.push_back(bytes[i][7:4]);
      end
      if (odd) nq.push_back(4'h0);
    end
    // gap with optional carrier pattern
    repeat (3) @(negedge clk) begin mii_rxdv = 0; mii_rxer = 0; mii_rxd = 0; end
    if (car != 0) begin
      @(negedge clk);
      mii_rxer = 1'b1;
      mii_rxd  = (car == 1) ? 4'hE : 4'hF;
    end
    foreach (nq[i]) begin
      @(negedge clk);
      mii_rxdv    = 1'b1;
      mii_rxd     = nq[i];
      mii_rxer    = (i == cv_at);
      buf_overrun = ovr && (i == 0);
    end
    @(negedge clk);
    mii_rxdv = 0; mii_rxd = 0; mii_rxer = 0; buf_overrun = 0; crc_match = crc;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset vld", 32'(stat_vld), 0);
    check("R1 reset word", 32'(stat_word), 0);
    check("R1 reset accept", 32'(stat_accept), 0);
    rst = 1'b0;
    mon_on = 1'b1;

    // R12 / R11 good unicast
    do_frame("R11 R12 unicast good", 15, -1, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 0);
    do_frame("R12 unicast other", 15, -1, 1, OTHER, 16'h0800, 64, 0, -1, 0, 1, 0);
    // R10 broadcast / multicast
    do_frame("R10 bcast on", 15, -1, 1, BCAST, 16'h0800, 64, 0, -1, 0, 1, 0);
    cfg_bcast_en = 1'b0;
    do_frame("R12 bcast off", 15, -1, 1, BCAST, 16'h0800, 64, 0, -1, 0, 1, 0);
    do_frame("R10 mcast off", 15, -1, 1, MCAST, 16'h0800, 64, 0, -1, 0, 1, 0);
    cfg_mcast_en = 1'b1;
    do_frame("R12 mcast on", 15, -1, 1, MCAST, 16'h0800, 64, 0, -1, 0, 1, 0);
    cfg_promisc = 1'b1;
    do_frame("R12 promisc", 15, -1, 1, OTHER, 16'h0800, 64, 0, -1, 0, 1, 0);
    cfg_promisc = 1'b0;
    cfg_bcast_en = 1'b1;
    // R2 preamble purity
    do_frame("R2 impure checked", 15, 3, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 0);
    do_frame("R2 no sfd checked", 10, -1, 0, STA, 16'h0800, 64, 0, -1, 0, 1, 0);
    cfg_pure_chk = 1'b0;
    do_frame("R2 impure unchecked", 15, 3, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 0);
    do_frame("R2 no sfd unchecked", 10, -1, 0, STA, 16'h0800, 64, 0, -1, 0, 1, 0);
    cfg_pure_chk = 1'b1;
    // R3 long preamble
    do_frame("R3 22 nibbles", 22, -1, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 0);
    do_frame("R3 23 nibbles", 23, -1, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 0);
    cfg_long_pre_rej = 1'b0;
    do_frame("R3 23 nibbles off", 23, -1, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 0);
    cfg_long_pre_rej = 1'b1;
    // R4 long event boundary (dur 300 vs 301)
    do_frame("R4 at limit", 15, -1, 1, STA, 16'h0800, 142, 0, -1, 0, 1, 0);
    do_frame("R4 over limit", 16, -1, 1, STA, 16'h0800, 142, 0, -1, 0, 1, 0);
    // R5 alignment
    do_frame("R5 odd nibble", 15, -1, 1, STA, 16'h0800, 64, 1, -1, 0, 1, 0);
    // R9 short boundary
    do_frame("R9 63 bytes", 15, -1, 1, STA, 16'h0800, 63, 0, -1, 0, 1, 0);
    do_frame("R9 40 bytes", 15, -1, 1, STA, 16'h0800, 40, 0, -1, 0, 1, 0);
    // R8 length/type
    do_frame("R8 length match", 15, -1, 1, STA, 16'd46, 64, 0, -1, 0, 1, 0);
    do_frame("R8 length mismatch", 15, -1, 1, STA, 16'd100, 64, 0, -1, 0, 1, 0);
    do_frame("R8 length 1518", 15, -1, 1, STA, 16'd1518, 64, 0, -1, 0, 1, 0);
    do_frame("R8 out of range", 15, -1, 1, STA, 16'd1520, 64, 0, -1, 0, 1, 0);
    do_frame("R8 vlan", 15, -1, 1, STA, 16'h8100, 64, 0, -1, 0, 1, 0);
    // R7 code violation / overrun
    do_frame("R7 code violation", 15, -1, 1, STA, 16'h0800, 64, 0, 20, 0, 1, 0);
    do_frame("R7 overrun", 15, -1, 1, STA, 16'h0800, 64, 0, -1, 1, 1, 0);
    // R11 crc
    do_frame("R11 crc bad", 15, -1, 1, STA, 16'h0800, 64, 0, -1, 0, 0, 0);
    // R6 carrier event
    do_frame("R6 carrier", 15, -1, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 1);
    do_frame("R6 decoy", 15, -1, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 2);
    do_frame("R11 final good", 15, -1, 1, STA, 16'h0800, 64, 0, -1, 0, 1, 0);

    repeat (5) @(negedge clk);
    check("R1 all status seen", 32'(exp_word_q.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule